// File: doc/BRIEF.md
# Compare Timer with Reset/Set PWM Output

A 16-bit timer peripheral on a simple register bus. A clock-source select field picks one of four enable strobes, and a prescaler divides the selected strobe by 1, 2, 4 or 8. The resulting tick advances a counter in one of four modes: stop, up to a period register, free-running across the whole 16-bit range, or up then down. Period register 0 fixes the period in up and up/down modes, and its match sets a compare flag. A second compare register drives a PWM pin in reset/set fashion. Two sticky flags feed one interrupt request: an overflow flag and a channel-0 compare flag. Each flag has its own enable.

Software configures the timer by writing registers. It reads the count and the flags back, and it clears a flag by writing a 0 to that flag's bit. The usual setup for PWM is up mode, a period value P and a duty value D. The pin is then high for count values below D and at P, and low from D to P-1.

Register map (3-bit word address, 16-bit data):
- 0, control: [1:0] source select, [3:2] divider, [5:4] mode, [6] clear (write-only, reads 0), [7] overflow interrupt enable, [8] overflow flag.
- 1, count: read-only.
- 2, channel-0 control: [0] compare interrupt enable, [1] compare flag.
- 3: period register 0.
- 4: compare register 1.
- 5: output mode in bits [2:0].

Top module: `tmr_pwm`

## Requirements
- R1: After reset, every register reads 0, pwm_o is 0 and irq_o is 0.
- R2: With mode 0 (stop), the count holds its value and pwm_o keeps its level.
- R3: With mode 1 (up), the count runs 0,1,..,period,0 with one step per tick. The overflow flag (control bit 8) sets on the step from the period value to 0.
- R4: With mode 2 (free-running), the count wraps from 0xFFFF to 0, and the overflow flag sets on that step.
- R5: With mode 3 (up/down), the count runs 0 up to the period value and back down to 0. The overflow flag sets on the step from 1 to 0.
- R6: The divider field (control bits [3:2]) encodes 0,1,2,3 as ratios 1,2,4,8. After a clear, the first count step comes on the ratio-th selected strobe.
- R7: The source select field (control bits [1:0]) picks bit n of src_en_i, and the count advances only on strobes of that bit.
- R8: Writing control bit 6 as 1 resets the count and the prescaler to 0, and the bit reads back as 0.
- R9: A flag is cleared by writing 0 to its bit, and writing 1 to it has no effect. When a set event and a clearing write fall in the same cycle, the flag ends up set.
- R10: irq_o is high only when a set flag has its enable bit set (overflow: control bit 7, compare: channel-0 bit 0).
- R11: The compare flag (channel-0 bit 1) sets in the cycle in which the count reaches the period value.
- R12: With output mode 7, pwm_o goes low when the count reaches compare register 1 and high when it reaches the period value. With any other output mode, pwm_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data of the addressed register (combinational) |
| src_en_i | input | 4 | Clock-source enable strobes, one per source |
| irq_o | output | 1 | Interrupt request |
| pwm_o | output | 1 | Reset/set PWM output |

## Verification
The hardware setting a flag and software clearing it can fall in the same clock edge. The bench provokes this by writing 0 to the compare flag bit in exactly the cycle in which the count steps onto the period value, and it expects the flag to read as set afterwards. A second clearing write one cycle later, with no match in that cycle, must leave the flag at 0.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [1:0] {
    MODE_STOP = 2'd0,
    MODE_UP   = 2'd1,
    MODE_CONT = 2'd2,
    MODE_UPDN = 2'd3
  } tmr_mode_e;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CH0  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CCR0 = 3'd3;
  localparam logic [ADDR_W-1:0] A_CCR1 = 3'd4;
  localparam logic [ADDR_W-1:0] A_OMOD = 3'd5;

  // control register bit positions
  localparam int unsigned B_SRC   = 0;
  localparam int unsigned B_DIV   = 2;
  localparam int unsigned B_MODE  = 4;
  localparam int unsigned B_CLR   = 6;
  localparam int unsigned B_OVFIE = 7;
  localparam int unsigned B_OVF   = 8;
  // channel-0 control bit positions
  localparam int unsigned B_CMPIE = 0;
  localparam int unsigned B_CMP   = 1;

  localparam int unsigned OMOD_W  = 3;
  localparam logic [OMOD_W-1:0] OMOD_RST_SET = 3'd7;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned N_SRC = 4,
  parameter int unsigned DIV_W = 2,
  localparam int unsigned SEL_W = $clog2(N_SRC),
  localparam int unsigned CW    = (1 << DIV_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             run_i,
  input  logic             clr_i,
  output logic             tick_o
);
  logic [CW-1:0] div_cnt_q;
  logic [CW-1:0] ratio_m1;
  logic          src_tick;
  logic          wrap;

  // ratio - 1 is a run of div_i ones
  always_comb begin
    ratio_m1 = '0;
    for (int i = 0; i < CW; i++) begin
      if (i < int'(div_i)) ratio_m1[i] = 1'b1;
    end
  end

  assign src_tick = src_en_i[sel_i];
  assign wrap     = (div_cnt_q >= ratio_m1);
  assign tick_o   = run_i & src_tick & wrap & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_cnt_q <= '0;
    end else if (clr_i) begin
      div_cnt_q <= '0;
    end else if (run_i && src_tick) begin
      div_cnt_q <= wrap ? '0 : div_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             clr_i,
  input  tmr_mode_e        mode_i,
  input  logic [CNT_W-1:0] ccr0_i,
  input  logic [CNT_W-1:0] ccr1_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_dn_o,
  output logic             ovf_evt_o,
  output logic             eq0_evt_o,
  output logic             eq1_evt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dn_q, dn_d;
  logic             ovf;

  always_comb begin
    cnt_d = cnt_q;
    dn_d  = dn_q;
    ovf   = 1'b0;
    if (tick_i) begin
      unique case (mode_i)
        MODE_UP: begin
          dn_d = 1'b0;
          if (cnt_q >= ccr0_i) begin
            cnt_d = '0;
            ovf   = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        MODE_CONT: begin
          dn_d  = 1'b0;
          cnt_d = cnt_q + 1'b1;
          ovf   = &cnt_q;
        end
        MODE_UPDN: begin
          if (ccr0_i == '0) begin
            cnt_d = '0;
            dn_d  = 1'b0;
          end else if (!dn_q) begin
            if (cnt_q >= ccr0_i) begin
              cnt_d = cnt_q - 1'b1;
              dn_d  = 1'b1;
              ovf   = (cnt_q == CNT_W'(1));
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end else if (cnt_q <= CNT_W'(1)) begin
            cnt_d = '0;
            dn_d  = 1'b0;
            ovf   = (cnt_q == CNT_W'(1));
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign ovf_evt_o = ovf;
  assign eq0_evt_o = tick_i & (cnt_d == ccr0_i);
  assign eq1_evt_o = tick_i & (cnt_d == ccr1_i);
  assign cnt_o     = cnt_q;
  assign dir_dn_o  = dn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dn_q  <= dn_d;
    end
  end
endmodule

// File: rtl/tmr_outunit.sv
module tmr_outunit
  import tmr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OMOD_W-1:0] omod_i,
  input  logic              set_i,
  input  logic              rst_i,
  output logic              out_o
);
  logic out_q;

  // set dominates when both compares hit in one tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     out_q <= 1'b0;
    else if (omod_i != OMOD_RST_SET) out_q <= 1'b0;
    else if (set_i)                  out_q <= 1'b1;
    else if (rst_i)                  out_q <= 1'b0;
  end

  assign out_o = out_q;
endmodule

// File: rtl/tmr_pwm.sv
module tmr_pwm
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned N_SRC = 4,
  parameter int unsigned DIV_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [N_SRC-1:0]  src_en_i,
  output logic              irq_o,
  output logic              pwm_o
);
  localparam int unsigned SEL_W = $clog2(N_SRC);

  logic [SEL_W-1:0]  src_sel_q;
  logic [DIV_W-1:0]  div_q;
  tmr_mode_e         mode_q;
  logic              ovf_ie_q, ovf_flag_q;
  logic              cmp_ie_q, cmp_flag_q;
  logic [CNT_W-1:0]  ccr0_q, ccr1_q;
  logic [OMOD_W-1:0] out_mode_q;

  logic wr_ctrl, wr_ch0, wr_ccr0, wr_ccr1, wr_omod;
  logic clr_wr, tick, dir_dn;
  logic ovf_evt, eq0_evt, eq1_evt;
  logic [CNT_W-1:0] cnt_q;

  assign wr_ctrl = bus_we_i & (bus_addr_i == A_CTRL);
  assign wr_ch0  = bus_we_i & (bus_addr_i == A_CH0);
  assign wr_ccr0 = bus_we_i & (bus_addr_i == A_CCR0);
  assign wr_ccr1 = bus_we_i & (bus_addr_i == A_CCR1);
  assign wr_omod = bus_we_i & (bus_addr_i == A_OMOD);
  assign clr_wr  = wr_ctrl & bus_wdata_i[B_CLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_sel_q  <= '0;
      div_q      <= '0;
      mode_q     <= MODE_STOP;
      ovf_ie_q   <= 1'b0;
      cmp_ie_q   <= 1'b0;
      ccr0_q     <= '0;
      ccr1_q     <= '0;
      out_mode_q <= '0;
    end else begin
      if (wr_ctrl) begin
        src_sel_q <= bus_wdata_i[B_SRC +: SEL_W];
        div_q     <= bus_wdata_i[B_DIV +: DIV_W];
        mode_q    <= tmr_mode_e'(bus_wdata_i[B_MODE +: 2]);
        ovf_ie_q  <= bus_wdata_i[B_OVFIE];
      end
      if (wr_ch0)  cmp_ie_q   <= bus_wdata_i[B_CMPIE];
      if (wr_ccr0) ccr0_q     <= bus_wdata_i[CNT_W-1:0];
      if (wr_ccr1) ccr1_q     <= bus_wdata_i[CNT_W-1:0];
      if (wr_omod) out_mode_q <= bus_wdata_i[OMOD_W-1:0];
    end
  end

  // flags: hardware set beats a clearing write; writing 1 keeps the flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_flag_q <= 1'b0;
      cmp_flag_q <= 1'b0;
    end else begin
      ovf_flag_q <= ovf_evt | (ovf_flag_q & ~(wr_ctrl & ~bus_wdata_i[B_OVF]));
      cmp_flag_q <= eq0_evt | (cmp_flag_q & ~(wr_ch0 & ~bus_wdata_i[B_CMP]));
    end
  end

  tmr_prescale #(
    .N_SRC(N_SRC),
    .DIV_W(DIV_W)
  ) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_en_i(src_en_i),
    .sel_i   (src_sel_q),
    .div_i   (div_q),
    .run_i   (mode_q != MODE_STOP),
    .clr_i   (clr_wr),
    .tick_o  (tick)
  );

  tmr_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .clr_i    (clr_wr),
    .mode_i   (mode_q),
    .ccr0_i   (ccr0_q),
    .ccr1_i   (ccr1_q),
    .cnt_o    (cnt_q),
    .dir_dn_o (dir_dn),
    .ovf_evt_o(ovf_evt),
    .eq0_evt_o(eq0_evt),
    .eq1_evt_o(eq1_evt)
  );

  tmr_outunit u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .omod_i(out_mode_q),
    .set_i (eq0_evt),
    .rst_i (eq1_evt),
    .out_o (pwm_o)
  );

  assign irq_o = (ovf_ie_q & ovf_flag_q) | (cmp_ie_q & cmp_flag_q);

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      A_CTRL: begin
        bus_rdata_o[B_SRC +: SEL_W]  = src_sel_q;
        bus_rdata_o[B_DIV +: DIV_W]  = div_q;
        bus_rdata_o[B_MODE +: 2]     = mode_q;
        bus_rdata_o[B_OVFIE]         = ovf_ie_q;
        bus_rdata_o[B_OVF]           = ovf_flag_q;
      end
      A_CNT:  bus_rdata_o[CNT_W-1:0]  = cnt_q;
      A_CH0: begin
        bus_rdata_o[B_CMPIE] = cmp_ie_q;
        bus_rdata_o[B_CMP]   = cmp_flag_q;
      end
      A_CCR0: bus_rdata_o[CNT_W-1:0]  = ccr0_q;
      A_CCR1: bus_rdata_o[CNT_W-1:0]  = ccr1_q;
      A_OMOD: bus_rdata_o[OMOD_W-1:0] = out_mode_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/tmr_pwm_chk.sv
module tmr_pwm_chk
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input tmr_mode_e         mode_q,
  input logic              tick,
  input logic              clr_wr,
  input logic              dir_dn,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  ccr0_q,
  input logic              ovf_flag_q,
  input logic              ovf_ie_q,
  input logic              cmp_ie_q,
  input logic [OMOD_W-1:0] out_mode_q,
  input logic              pwm_o,
  input logic              irq_o
);
  p_stop_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_STOP && !clr_wr) |=> $stable(cnt_q));

  p_stop_pwm_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_STOP && out_mode_q == OMOD_RST_SET &&
     !(bus_we_i && bus_addr_i == A_OMOD)) |=> $stable(pwm_o));

  p_up_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_UP && tick && cnt_q >= ccr0_q) |=> (cnt_q == '0 && ovf_flag_q));

  p_updn_bottom_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_UPDN && tick && dir_dn && cnt_q == CNT_W'(1)) |=>
      (cnt_q == '0 && ovf_flag_q && !dir_dn));

  p_clr_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == A_CTRL && bus_wdata_i[B_CLR]) |=> (cnt_q == '0));

  p_flag_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_flag_q && !(bus_we_i && bus_addr_i == A_CTRL && !bus_wdata_i[B_OVF])) |=> ovf_flag_q);

  p_irq_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovf_ie_q && !cmp_ie_q) |-> !irq_o);
endmodule

bind tmr_pwm tmr_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .mode_q     (mode_q),
  .tick       (tick),
  .clr_wr     (clr_wr),
  .dir_dn     (dir_dn),
  .cnt_q      (cnt_q),
  .ccr0_q     (ccr0_q),
  .ovf_flag_q (ovf_flag_q),
  .ovf_ie_q   (ovf_ie_q),
  .cmp_ie_q   (cmp_ie_q),
  .out_mode_q (out_mode_q),
  .pwm_o      (pwm_o),
  .irq_o      (irq_o)
);

// File: tb/tmr_pwm_tb_top.sv
module tmr_pwm_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0]  src_en = 4'b0100;
  logic        irq, pwm;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_pwm dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .bus_we_i   (we),
    .bus_addr_i (addr),
    .bus_wdata_i(wdata),
    .bus_rdata_o(rdata),
    .src_en_i   (src_en),
    .irq_o      (irq),
    .pwm_o      (pwm)
  );

  typedef struct {
    string       req;
    logic [15:0] exp;
    logic [15:0] act;
  } sb_item_t;

  sb_item_t sb_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // driver side: push observed/expected pair
  task automatic expect_eq(input string req, input logic [15:0] act, input logic [15:0] exp);
    sb_item_t it;
    it.req = req; it.exp = exp; it.act = act;
    sb_q.push_back(it);
  endtask

  task automatic drain();
    while (sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      n_cmp++;
      if (it.act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.req, it.act, it.exp);
      end
    end
  endtask

  // monitor: compares queued items as results arrive
  always @(posedge clk) drain();

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic check_reg(input string req, input logic [2:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    expect_eq(req, v, exp);
  endtask

  task automatic finish_run();
    drain();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [15:0] v;
    step(2);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    check_reg("R1 ctrl", 3'd0, 16'h0000);
    check_reg("R1 count", 3'd1, 16'h0000);
    check_reg("R1 ch0", 3'd2, 16'h0000);
    check_reg("R1 ccr0", 3'd3, 16'h0000);
    expect_eq("R1 pwm", {15'd0, pwm}, 16'd0);
    expect_eq("R1 irq", {15'd0, irq}, 16'd0);

    // R3 / R11 up mode, period 4
    wr(3'd3, 16'd4);
    wr(3'd0, 16'h0052);
    check_reg("R8 clear bit reads 0", 3'd0, 16'h0012);
    check_reg("R3 count start", 3'd1, 16'd0);
    for (int i = 1; i <= 6; i++) begin
      step(1);
      check_reg("R3 up count", 3'd1, 16'(i % 5));
      if (i == 4) begin
        check_reg("R11 cmp flag at period", 3'd2, 16'h0002);
        check_reg("R3 no ovf before wrap", 3'd0, 16'h0012);
      end
      if (i == 5) check_reg("R3 ovf at wrap", 3'd0, 16'h0112);
    end

    // R10 interrupt gating
    expect_eq("R10 irq masked", {15'd0, irq}, 16'd0);
    wr(3'd0, 16'h0192);
    expect_eq("R10 irq ovf enabled", {15'd0, irq}, 16'd1);

    // R9 flag clear rules, R2 stop hold
    wr(3'd0, 16'h0002);
    check_reg("R9 ovf cleared by 0", 3'd0, 16'h0002);
    wr(3'd0, 16'h0102);
    check_reg("R9 ovf write 1 no set", 3'd0, 16'h0002);
    wr(3'd2, 16'h0003);
    expect_eq("R10 irq cmp enabled", {15'd0, irq}, 16'd1);
    wr(3'd2, 16'h0000);
    check_reg("R9 cmp cleared", 3'd2, 16'h0000);
    expect_eq("R10 irq off after clear", {15'd0, irq}, 16'd0);
    wr(3'd2, 16'h0002);
    check_reg("R9 cmp write 1 no set", 3'd2, 16'h0000);
    step(5);
    check_reg("R2 stop holds count", 3'd1, 16'd3);

    // R6 divider
    wr(3'd0, 16'h005A);
    step(3);
    check_reg("R6 div4 before tick", 3'd1, 16'd0);
    step(1);
    check_reg("R6 div4 first tick", 3'd1, 16'd1);
    step(4);
    check_reg("R6 div4 second tick", 3'd1, 16'd2);
    wr(3'd0, 16'h005E);
    step(5);
    wr(3'd0, 16'h005E);
    step(7);
    check_reg("R8 divider cleared", 3'd1, 16'd0);
    step(1);
    check_reg("R6 div8 first tick", 3'd1, 16'd1);
    wr(3'd0, 16'h0056);
    step(1);
    check_reg("R6 div2 before tick", 3'd1, 16'd0);
    step(1);
    check_reg("R6 div2 first tick", 3'd1, 16'd1);

    // R7 source select
    wr(3'd0, 16'h0051);
    step(5);
    check_reg("R7 idle source", 3'd1, 16'd0);
    src_en = 4'b0110;
    step(3);
    check_reg("R7 selected source", 3'd1, 16'd3);
    src_en = 4'b0100;

    // R5 up/down, period 3
    wr(3'd3, 16'd3);
    wr(3'd0, 16'h0072);
    for (int i = 1; i <= 8; i++) begin
      logic [15:0] e;
      step(1);
      e = (i <= 3) ? 16'(i) : (i <= 6) ? 16'(6 - i) : 16'(i - 6);
      check_reg("R5 updown count", 3'd1, e);
      if (i == 5) check_reg("R5 no ovf at 1", 3'd0, 16'h0032);
      if (i == 6) check_reg("R5 ovf at bottom", 3'd0, 16'h0132);
    end

    // R9 set wins over same-cycle clear
    wr(3'd3, 16'd4);
    wr(3'd2, 16'h0000);
    wr(3'd0, 16'h0052);
    step(3);
    check_reg("R3 count before match", 3'd1, 16'd3);
    wr(3'd2, 16'h0000);
    check_reg("R9 set wins over clear", 3'd2, 16'h0002);
    wr(3'd2, 16'h0000);
    check_reg("R9 clear without match", 3'd2, 16'h0000);

    // R12 reset/set PWM, period 9, duty 5
    wr(3'd3, 16'd9);
    wr(3'd4, 16'd5);
    wr(3'd5, 16'd7);
    wr(3'd0, 16'h0052);
    step(9);
    check_reg("R12 count at period", 3'd1, 16'd9);
    expect_eq("R12 set at period", {15'd0, pwm}, 16'd1);
    for (int k = 10; k < 30; k++) begin
      step(1);
      rd(3'd1, v);
      expect_eq("R12 count trace", v, 16'(k % 10));
      expect_eq("R12 pwm level", {15'd0, pwm}, (v >= 16'd5 && v < 16'd9) ? 16'd0 : 16'd1);
    end
    step(6);
    expect_eq("R12 low after duty", {15'd0, pwm}, 16'd0);
    wr(3'd0, 16'h0002);
    step(4);
    check_reg("R2 stop count", 3'd1, 16'd6);
    expect_eq("R2 stop pwm level", {15'd0, pwm}, 16'd0);
    wr(3'd5, 16'd0);
    expect_eq("R12 other mode forces 0", {15'd0, pwm}, 16'd0);

    // R4 free-running wrap
    wr(3'd0, 16'h0062);
    step(65535);
    check_reg("R4 count at top", 3'd1, 16'hFFFF);
    check_reg("R4 no ovf at top", 3'd0, 16'h0022);
    step(1);
    check_reg("R4 count wrapped", 3'd1, 16'h0000);
    check_reg("R4 ovf at wrap", 3'd0, 16'h0122);

    step(2);
    if (!done) begin
      done = 1'b1;
      finish_run();
    end
  end
endmodule